// File: doc/BRIEF.md
# Integrate-and-Fire Neuron Processing Element

This block is one digital integrate-and-fire neuron, the basic processing element of an event-driven spiking accelerator. It holds a signed membrane potential in a register and works in two phases picked by a mode input. In the accumulate phase, each cycle with a spike present adds a signed synaptic weight to the potential. Cycles with no spike leave the potential as it is. In the fire phase, the potential is compared with a signed threshold. If the potential is strictly greater, the element produces a one-cycle output spike and reloads the potential with the reset value, which is zero.

The neuron has no leak and no refractory period, so its output spike rate follows a ReLU of its weighted input rate. The accumulator clamps at the signed limits of the data width and does not wrap. A synchronous clear input zeroes the potential at the start of each frame. Weight storage and spike routing belong to the surrounding array.

Top module: `if_neuron_pe`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, potential is 0 and spike_out is 0.
- R2: With accumulate=1, clear=0 and spike_in=1, potential becomes potential+weight after the clock edge (two's complement, 10 bits by default).
- R3: With accumulate=1, clear=0 and spike_in=0, potential keeps its value and weight has no effect on it.
- R4: A positive sum above +511 gives potential = +511 (saturation, no wrap).
- R5: A negative sum below -512 gives potential = -512 (saturation, no wrap).
- R6: With accumulate=0, clear=0 and potential strictly greater than threshold, spike_out is 1 for the following cycle and potential becomes 0.
- R7: With accumulate=0, clear=0 and potential less than or equal to threshold, spike_out stays 0 and potential keeps its value.
- R8: spike_out is high only in the cycle after a fire-phase cycle that met the R6 condition. In every other cycle it is 0.
- R9: clear=1 takes priority over the mode: potential becomes 0 and spike_out 0 after the edge.
- R10: The threshold comparison is signed, so a negative threshold fires on a zero or a smaller negative potential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Frame-start clear of the potential |
| accumulate | input | 1 | 1 = accumulate phase, 0 = fire phase |
| spike_in | input | 1 | Presynaptic spike for this cycle |
| weight | input | DATA_W | Signed synaptic weight |
| threshold | input | DATA_W | Signed firing threshold |
| spike_out | output | 1 | Registered output spike pulse |
| potential | output | DATA_W | Signed membrane potential |

## Verification
The hardest states to reach are the two saturation rails, and firing exactly at the boundary where the potential equals the threshold. Random weights seldom drive the sum to a rail and then hold it there. Directed runs of large same-sign weights therefore push the potential onto each rail and then past it. The threshold is then set to the exact current potential, and to one below it, to test the strict comparison. Random phases with negative thresholds cover the signed comparison from ports alone.

// File: rtl/if_neuron_pkg.sv
package if_neuron_pkg;
   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_ACCUM = 2'd1,
      OP_FIRE  = 2'd2
   } neuron_op_e;

   function automatic neuron_op_e decode_op(input logic clr, input logic acc);
      if (clr)      return OP_CLEAR;
      else if (acc) return OP_ACCUM;
      else          return OP_FIRE;
   endfunction
endpackage

// File: rtl/if_neuron_accum.sv
module if_neuron_accum #(
   parameter int DATA_W   = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [DATA_W-1:0] acc_in,
   input  logic signed [DATA_W-1:0] addend,
   output logic signed [DATA_W-1:0] acc_out
);
   localparam int EXT_W = DATA_W + 1;
   localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

   if (DATA_W < 2) begin : g_bad_width
      $error("if_neuron_accum: DATA_W must be at least 2");
   end

   logic signed [EXT_W-1:0] wide_sum;
   assign wide_sum = {acc_in[DATA_W-1], acc_in} + {addend[DATA_W-1], addend};

   if (SATURATE) begin : g_sat
      always_comb begin
         if (wide_sum[EXT_W-1] != wide_sum[EXT_W-2])
            acc_out = wide_sum[EXT_W-1] ? MIN_V : MAX_V;
         else
            acc_out = wide_sum[DATA_W-1:0];
      end

      always_comb begin
         if (!$isunknown({acc_in, addend}) && (acc_in[DATA_W-1] == addend[DATA_W-1]))
            AST_NO_OVERFLOW: assert (acc_out[DATA_W-1] == acc_in[DATA_W-1]); // R4
      end
   end else begin : g_wrap
      assign acc_out = wide_sum[DATA_W-1:0];
   end
endmodule

// File: rtl/if_neuron_cmp.sv
module if_neuron_cmp #(
   parameter int DATA_W    = 10,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic signed [DATA_W-1:0] level,
   input  logic signed [DATA_W-1:0] limit,
   output logic                     above
);
   if (DATA_W < 2) begin : g_bad_width
      $error("if_neuron_cmp: DATA_W must be at least 2");
   end

   if (INCLUSIVE) begin : g_ge
      assign above = (level >= limit);
   end else begin : g_gt
      assign above = (level > limit);
   end
endmodule

// File: rtl/if_neuron_pe.sv
module if_neuron_pe #(
   parameter int DATA_W    = 10,
   parameter int RESET_VAL = 0,
   parameter bit SATURATE  = 1'b1,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              accumulate,
   input  logic              spike_in,
   input  logic [DATA_W-1:0] weight,
   input  logic [DATA_W-1:0] threshold,
   output logic              spike_out,
   output logic [DATA_W-1:0] potential
);
   import if_neuron_pkg::*;

   localparam int MAX_I = (1 << (DATA_W-1)) - 1;
   localparam int MIN_I = -(1 << (DATA_W-1));
   localparam logic signed [DATA_W-1:0] RST_V = DATA_W'(RESET_VAL);

   if (DATA_W < 2 || DATA_W > 30) begin : g_bad_width
      $error("if_neuron_pe: DATA_W out of range");
   end
   if (RESET_VAL > MAX_I || RESET_VAL < MIN_I) begin : g_bad_reset
      $error("if_neuron_pe: RESET_VAL does not fit DATA_W");
   end

   logic signed [DATA_W-1:0] pot_q, pot_d, sum_w;
   logic                     spk_q, spk_d, over_thr;
   neuron_op_e               op;

   assign op = decode_op(clear, accumulate);

   if_neuron_accum #(.DATA_W(DATA_W), .SATURATE(SATURATE)) u_accum (
      .acc_in (pot_q),
      .addend ($signed(weight)),
      .acc_out(sum_w)
   );

   if_neuron_cmp #(.DATA_W(DATA_W), .INCLUSIVE(INCLUSIVE)) u_cmp (
      .level(pot_q),
      .limit($signed(threshold)),
      .above(over_thr)
   );

   always_comb begin
      pot_d = pot_q;
      spk_d = 1'b0;
      unique case (op)
         OP_CLEAR: pot_d = '0;
         OP_ACCUM: if (spike_in) pot_d = sum_w;
         OP_FIRE: begin
            if (over_thr) begin
               spk_d = 1'b1;
               pot_d = RST_V;
            end
         end
         default: pot_d = pot_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pot_q <= '0;
         spk_q <= 1'b0;
      end else begin
         pot_q <= pot_d;
         spk_q <= spk_d;
      end
   end

   assign potential = pot_q;
   assign spike_out = spk_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (accumulate && !spike_in && !clear) |=> $stable(potential)); // R3
   AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      spike_out |-> ($signed(potential) == RST_V)); // R6
   AST_SPIKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      spike_out |-> $past(!accumulate && !clear)); // R8
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (potential == '0 && !spike_out)); // R9
   AST_NO_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!accumulate && !clear && ($signed(potential) <= $signed(threshold))) |=>
      (!spike_out && $stable(potential))); // R7
endmodule

// File: tb/if_neuron_pe_test.sv
`timescale 1ns/1ps
module if_neuron_pe_test;
   localparam int W = 10;
   localparam int MAXV = 511;
   localparam int MINV = -512;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clear = 1'b0;
   logic         accumulate = 1'b0;
   logic         spike_in = 1'b0;
   logic [W-1:0] weight = '0;
   logic [W-1:0] threshold = '0;
   logic         spike_out;
   logic [W-1:0] potential;

   int total = 0;
   int bad = 0;
   int model_pot = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   if_neuron_pe uut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .accumulate(accumulate),
      .spike_in(spike_in), .weight(weight), .threshold(threshold),
      .spike_out(spike_out), .potential(potential)
   );

   function automatic int sat_add(input int a, input int b);
      int s;
      s = a + b;
      if (s > MAXV) s = MAXV;
      if (s < MINV) s = MINV;
      return s;
   endfunction

   function automatic int to_int(input logic [W-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input bit c, input bit a, input bit s, input int w, input int t);
      int    exp_pot;
      bit    exp_spk;
      int    raw;
      string tag;
      @(negedge clk);
      clear = c; accumulate = a; spike_in = s;
      weight = W'(w); threshold = W'(t);
      exp_pot = model_pot;
      exp_spk = 1'b0;
      if (c) begin
         exp_pot = 0; tag = "R9";
      end else if (a) begin
         if (s) begin
            raw = model_pot + to_int(W'(w));
            exp_pot = sat_add(model_pot, to_int(W'(w)));
            tag = (raw > MAXV) ? "R4" : (raw < MINV) ? "R5" : "R2";
         end else tag = "R3";
      end else begin
         if (model_pot > to_int(W'(t))) begin
            exp_spk = 1'b1; exp_pot = 0;
            tag = (to_int(W'(t)) < 0) ? "R10" : "R6";
         end else tag = (to_int(W'(t)) < 0) ? "R10" : "R7";
      end
      @(posedge clk);
      #1;
      check(tag, to_int(potential), exp_pot);
      check(exp_spk ? tag : "R8", int'(spike_out), int'(exp_spk));
      model_pot = exp_pot;
   endtask

   initial begin
      int seed_v;
      seed_v = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      #1;
      check("R1", to_int(potential), 0);
      check("R1", int'(spike_out), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", to_int(potential), 0);
      check("R1", int'(spike_out), 0);

      step(0, 1, 1, 100, 0);   // R2
      step(0, 1, 0, 300, 0);   // R3 weight ignored
      repeat (4) step(0, 1, 1, 200, 0); // R4 rail
      step(0, 0, 0, 0, MAXV);  // R7 equal, no fire
      step(0, 0, 0, 0, MAXV-1); // R6 fire
      step(0, 1, 0, 0, 0);     // R8 pulse ends
      repeat (4) step(0, 1, 1, -200, 0); // R5 rail
      step(0, 0, 0, 0, MINV);  // R10 equal, no fire
      step(0, 1, 1, 509, 0);   // R2 back to -3
      step(0, 0, 0, 0, -10);   // R10 fire
      step(0, 0, 0, 0, -1);    // R10 zero fires on -1
      step(0, 1, 1, 50, 0);
      step(1, 1, 1, 50, 0);    // R9 clear beats accumulate
      step(0, 1, 1, 50, 0);
      step(1, 0, 0, 0, -100);  // R9 clear beats fire

      for (int i = 0; i < 3000; i++) begin
         bit c, a, s;
         int w, t;
         c = ($urandom_range(0, 31) == 0);
         a = ($urandom_range(0, 3) != 0);
         s = ($urandom_range(0, 2) != 0);
         w = $urandom_range(0, 1) ? $urandom_range(0, 255) : -$urandom_range(0, 255);
         t = int'($urandom_range(0, 1023)) - 512;
         step(c, a, s, w, t);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule